// File: doc/BRIEF.md
# Serial Register Access Slave

This block is a two-wire serial slave that gives an external host read and write access to a small register space. It samples the bus clock and data lines with a fast system clock and finds START, repeated START and STOP conditions on the sampled lines. It accepts a transaction only when the identification byte carries the fixed four-bit prefix and three bits that match the strap inputs. The data line is driven only as an open-drain pull-down enable.

A write carries an address byte and exactly one data byte. The data byte goes to the register side as a single-cycle strobe. A read starts with a dummy write of the address, then a repeated START and an identification byte with the read bit set. The slave then streams bytes from an internal pointer that advances after every byte sent and wraps to zero after location 0Fh. On the register side the slave offers a pointer/address output, write data, a write strobe, a combinational read-data input and a STOP pulse.

Top module: `i2c_reg_slave`

## Requirements
- R1: The identification byte is accepted only when bits [7:4] equal 1010b and bits [3:1] equal strap_i[2:0]. Bit 0 is the direction (1 = read, 0 = write). On a mismatch the slave does not pull SDA low in the ninth clock, and it ignores every further bit until the next START.
- R2: Bytes travel most significant bit first. SDA is sampled on SCL rising edges. The slave changes sda_oe_o only after an SCL falling edge, a START, a STOP or while not initialised.
- R3: A write is START, identification byte (bit 0 = 0), address byte, one data byte, STOP. The slave ACKs all three bytes. After the ninth clock of the data byte it issues one write strobe with the received address and data. Any further data byte in the same transfer is not ACKed and causes no strobe.
- R4: A read is START, identification (write), address, repeated START, identification (read). All three bytes are ACKed. The slave then returns the register-side data at the pointer, MSB first.
- R5: The slave sends another byte each time the master ACKs in the ninth clock. After a master NACK it keeps SDA released until the next START.
- R6: The pointer starts at the received address and advances by one after each byte sent. From 0Fh, or from any value above 0Fh, it goes to 00h.
- R7: Bus activity before a START is ignored. While init_done_i is low, START and STOP are ignored and SDA is never pulled low.
- R8: A STOP returns the slave to idle, releases SDA and produces a one-cycle stop_o pulse. Reset leaves SDA released and every strobe low.
- R9: reg_we_o is high for exactly one system clock per accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| init_done_i | input | 1 | High once the power-up sequence has completed |
| strap_i | input | 3 | Address strap bits compared with identification bits [3:1] |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | Pull SDA low when high |
| reg_addr_o | output | 8 | Current register pointer |
| reg_wdata_o | output | 8 | Write data |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_rdata_i | input | 8 | Register-side read data at reg_addr_o |
| stop_o | output | 1 | One-cycle pulse on STOP |

## Verification
Each bus edge reaches the control logic after the two synchroniser stages and one edge register. SDA drive, the write strobe and the STOP pulse therefore appear a few system clocks after the SCL or SDA edge that causes them, well within the ten-clock quarter period the bench uses for SCL. The bench samples ACK and data bits in the middle of SCL high. It compares every write strobe against a queue of expected address/data pairs in the clock cycle in which the strobe appears, rather than at a fixed offset. STOP pulses are counted each clock and matched against the number of STOPs sent after initialisation.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ID,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA,
    ST_RACK
  } slv_state_e;
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q, scl_s, sda_s;

  // bus idles high, so reset the pipes high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  assign scl_s      = scl_pipe[STAGES-1];
  assign sda_s      = sda_pipe[STAGES-1];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_ptr_step.sv
module i2c_ptr_step #(
  parameter int             W    = 8,
  parameter logic [W-1:0]   LAST = 'h0F
) (
  input  logic [W-1:0] ptr_i,
  output logic [W-1:0] next_o
);
  // anything at or beyond the last location folds back to zero
  assign next_o = (ptr_i >= LAST) ? '0 : ptr_i + 1'b1;
endmodule

// File: rtl/i2c_slv_fsm.sv
module i2c_slv_fsm
  import i2c_slv_pkg::*;
#(
  parameter int                 STRAP_W   = 3,
  parameter int                 PREFIX_W  = BYTE_W - 1 - STRAP_W,
  parameter logic [PREFIX_W-1:0] ID_PREFIX = 'b1010,
  parameter logic [BYTE_W-1:0]  LAST_ADDR = 8'h0F
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               init_done_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               sda_s_i,
  input  logic               scl_rise_i,
  input  logic               scl_fall_i,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic [BYTE_W-1:0]  rdata_i,
  output logic               sda_oe_o,
  output logic [BYTE_W-1:0]  ptr_o,
  output logic [BYTE_W-1:0]  wdata_o,
  output logic               we_o,
  output logic               stop_o
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  slv_state_e        state_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [BYTE_W-1:0] sh_q, ptr_q, ptr_next, wdata_q;
  logic              oe_q, ack_phase_q, rw_q, mack_q, we_q, stop_q;
  logic              id_ok;

  i2c_ptr_step #(.W(BYTE_W), .LAST(LAST_ADDR)) u_ptr_step (
    .ptr_i (ptr_q),
    .next_o(ptr_next)
  );

  assign id_ok = (sh_q[BYTE_W-1 -: PREFIX_W] == ID_PREFIX) &&
                 (sh_q[STRAP_W:1] == strap_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      bit_cnt_q   <= '0;
      sh_q        <= '0;
      ptr_q       <= '0;
      wdata_q     <= '0;
      oe_q        <= 1'b0;
      ack_phase_q <= 1'b0;
      rw_q        <= 1'b0;
      mack_q      <= 1'b0;
      we_q        <= 1'b0;
      stop_q      <= 1'b0;
    end else begin
      we_q   <= 1'b0;
      stop_q <= 1'b0;
      if (!init_done_i) begin
        state_q     <= ST_IDLE;
        oe_q        <= 1'b0;
        ack_phase_q <= 1'b0;
      end else if (stop_i) begin
        state_q     <= ST_IDLE;
        oe_q        <= 1'b0;
        ack_phase_q <= 1'b0;
        stop_q      <= 1'b1;
      end else if (start_i) begin
        state_q     <= ST_ID;
        bit_cnt_q   <= '0;
        oe_q        <= 1'b0;
        ack_phase_q <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ID, ST_ADDR, ST_WDATA: begin
            if (scl_rise_i && !ack_phase_q && bit_cnt_q != LAST_BIT) begin
              sh_q      <= {sh_q[BYTE_W-2:0], sda_s_i};
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (scl_fall_i && ack_phase_q) begin
              // end of our ACK clock
              oe_q        <= 1'b0;
              ack_phase_q <= 1'b0;
              bit_cnt_q   <= '0;
              if (state_q == ST_ID) begin
                if (rw_q) begin
                  state_q <= ST_RDATA;
                  sh_q    <= rdata_i;
                  oe_q    <= ~rdata_i[BYTE_W-1];
                end else begin
                  state_q <= ST_ADDR;
                end
              end else if (state_q == ST_ADDR) begin
                state_q <= ST_WDATA;
              end else begin
                we_q    <= 1'b1;
                wdata_q <= sh_q;
                state_q <= ST_IDLE;
              end
            end else if (scl_fall_i && bit_cnt_q == LAST_BIT) begin
              if (state_q == ST_ID) begin
                if (id_ok) begin
                  oe_q        <= 1'b1;
                  ack_phase_q <= 1'b1;
                  rw_q        <= sh_q[0];
                end else begin
                  state_q <= ST_IDLE;
                end
              end else begin
                oe_q        <= 1'b1;
                ack_phase_q <= 1'b1;
                if (state_q == ST_ADDR) ptr_q <= sh_q;
              end
            end
          end
          ST_RDATA: begin
            if (scl_rise_i && bit_cnt_q != LAST_BIT) begin
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (scl_fall_i && bit_cnt_q == LAST_BIT) begin
              oe_q    <= 1'b0;
              ptr_q   <= ptr_next;
              mack_q  <= 1'b0;
              state_q <= ST_RACK;
            end else if (scl_fall_i && bit_cnt_q != '0) begin
              sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
              oe_q <= ~sh_q[BYTE_W-2];
            end
          end
          ST_RACK: begin
            if (scl_rise_i) begin
              mack_q <= ~sda_s_i;
            end else if (scl_fall_i) begin
              if (mack_q) begin
                sh_q      <= rdata_i;
                oe_q      <= ~rdata_i[BYTE_W-1];
                bit_cnt_q <= '0;
                state_q   <= ST_RDATA;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o = oe_q;
  assign ptr_o    = ptr_q;
  assign wdata_o  = wdata_q;
  assign we_o     = we_q;
  assign stop_o   = stop_q;

  AST_PREINIT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_done_i |=> (state_q == ST_IDLE) && !oe_q); // R7

  AST_NACK_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RACK) |-> !oe_q); // R5
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2c_slv_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter int                STRAP_W     = 3,
  parameter logic [3:0]        ID_PREFIX   = 4'b1010,
  parameter logic [BYTE_W-1:0] LAST_ADDR   = 8'h0F
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         init_done_i,
  input  logic [2:0]   strap_i,
  input  logic         scl_i,
  input  logic         sda_i,
  output logic         sda_oe_o,
  output logic [7:0]   reg_addr_o,
  output logic [7:0]   reg_wdata_o,
  output logic         reg_we_o,
  input  logic [7:0]   reg_rdata_i,
  output logic         stop_o
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_o     (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  i2c_slv_fsm #(
    .STRAP_W  (STRAP_W),
    .PREFIX_W (4),
    .ID_PREFIX(ID_PREFIX),
    .LAST_ADDR(LAST_ADDR)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .init_done_i(init_done_i),
    .strap_i    (strap_i),
    .sda_s_i    (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .rdata_i    (reg_rdata_i),
    .sda_oe_o   (sda_oe_o),
    .ptr_o      (reg_addr_o),
    .wdata_o    (reg_wdata_o),
    .we_o       (reg_we_o),
    .stop_o     (stop_o)
  );

  AST_OE_AFTER_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> $past(scl_fall | start_det | stop_det | !init_done_i)); // R2

  AST_WE_AFTER_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> $past(scl_fall)); // R3

  AST_WE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o); // R9

  AST_STOP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |=> !stop_o); // R8

  AST_STOP_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_det && init_done_i) |=> !sda_oe_o && stop_o); // R8
endmodule

// File: tb/i2c_reg_slave_tb.sv
module i2c_reg_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int QTR        = 10;

  logic       clk = 1'b0, rst_n = 1'b0, init_done = 1'b0;
  logic       scl = 1'b1, sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic       sda_oe, reg_we, stop_p;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  wire        sda_line = sda_m & ~sda_oe;

  logic [7:0]  mem     [0:255];
  logic [7:0]  ref_mem [0:255];
  logic [15:0] exp_wq  [$];
  int total = 0, bad = 0, stops_seen = 0, stops_exp = 0;
  logic we_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_reg_slave u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .init_done_i(init_done),
    .strap_i    (strap),
    .scl_i      (scl),
    .sda_i      (sda_line),
    .sda_oe_o   (sda_oe),
    .reg_addr_o (reg_addr),
    .reg_wdata_o(reg_wdata),
    .reg_we_o   (reg_we),
    .reg_rdata_i(reg_rdata),
    .stop_o     (stop_p)
  );

  assign reg_rdata = mem[reg_addr];

  always @(posedge clk) if (reg_we) mem[reg_addr] <= reg_wdata;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock monitor: strobes against the expected queue, pulse widths
  always @(negedge clk) begin
    if (rst_n) begin
      if (reg_we) begin
        if (exp_wq.size() == 0) chk(1'b0, "R3 unexpected write strobe", {reg_addr, reg_wdata}, 0);
        else begin
          logic [15:0] e;
          e = exp_wq.pop_front();
          chk({reg_addr, reg_wdata} == e, "R3 write strobe addr/data", {reg_addr, reg_wdata}, e);
        end
        if (we_prev) chk(1'b0, "R9 strobe longer than one cycle", 2, 1);
      end
      if (stop_p) stops_seen++;
      we_prev = reg_we;
    end
  end

  task automatic wq();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
    if (init_done) stops_exp++;
  endtask

  task automatic tx_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl = 1'b1; wq(); scl = 1'b0;
    end
    sda_m = 1'b1; wq(); scl = 1'b1;
    repeat (QTR/2) @(negedge clk);
    ack = ~sda_line;
    repeat (QTR/2) @(negedge clk);
    scl = 1'b0;
  endtask

  task automatic rx_byte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl = 1'b1;
      repeat (QTR/2) @(negedge clk);
      b[i] = sda_line;
      repeat (QTR/2) @(negedge clk);
      scl = 1'b0;
    end
    sda_m = mack ? 1'b0 : 1'b1; wq(); scl = 1'b1; wq(); scl = 1'b0; wq(); sda_m = 1'b1;
  endtask

  function automatic logic [7:0] id_byte(input bit rd);
    return {4'b1010, strap, rd};
  endfunction

  task automatic do_write(input logic [7:0] a, input logic [7:0] d, output bit ok);
    bit k0, k1, k2;
    exp_wq.push_back({a, d});
    ref_mem[a] = d;
    bus_start();
    tx_byte(id_byte(1'b0), k0);
    tx_byte(a, k1);
    tx_byte(d, k2);
    bus_stop();
    ok = k0 & k1 & k2;
  endtask

  task automatic read_setup(input logic [7:0] a, output bit ok);
    bit k0, k1, k2;
    bus_start();
    tx_byte(id_byte(1'b0), k0);
    tx_byte(a, k1);
    bus_start();
    tx_byte(id_byte(1'b1), k2);
    ok = k0 & k1 & k2;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit ok, ack;
    logic [7:0] b;
    for (int i = 0; i < 256; i++) begin
      mem[i]     = 8'(i * 37 + 11);
      ref_mem[i] = 8'(i * 37 + 11);
    end
    repeat (5) @(negedge clk);
    chk(!sda_oe && !reg_we && !stop_p, "R8 reset state", {sda_oe, reg_we, stop_p}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R7: START and STOP while not initialised
    bus_start();
    tx_byte(id_byte(1'b0), ack);
    chk(!ack, "R7 no ACK before init done", ack, 0);
    bus_stop();
    chk(stops_seen == 0, "R7 no stop pulse before init done", stops_seen, 0);
    init_done = 1'b1;
    repeat (5) @(negedge clk);

    // R7: traffic without a START
    tx_byte(id_byte(1'b0), ack);
    chk(!ack, "R7 byte without START ignored", ack, 0);
    bus_stop();

    // R3: basic write
    do_write(8'h03, 8'hA5, ok);
    chk(ok, "R3 write ACKs", ok, 1);
    chk(exp_wq.size() == 0, "R9 write strobe issued once", exp_wq.size(), 0);
    chk(mem[3] == 8'hA5, "R3 register updated", mem[3], 8'hA5);

    // R1: bad prefix, then stays deaf
    bus_start();
    tx_byte({4'b1011, strap, 1'b0}, ack);
    chk(!ack, "R1 bad prefix NACK", ack, 0);
    tx_byte(8'h00, ack);
    chk(!ack, "R1 ignored after mismatch", ack, 0);
    bus_stop();

    // R1: strap mismatch
    bus_start();
    tx_byte({4'b1010, ~strap, 1'b0}, ack);
    chk(!ack, "R1 strap mismatch NACK", ack, 0);
    bus_stop();

    // R3: extra data byte not accepted
    exp_wq.push_back({8'h05, 8'h3C});
    ref_mem[5] = 8'h3C;
    bus_start();
    tx_byte(id_byte(1'b0), ack);
    tx_byte(8'h05, ack);
    tx_byte(8'h3C, ack);
    chk(ack, "R3 data byte ACK", ack, 1);
    tx_byte(8'h77, ack);
    chk(!ack, "R3 second data byte NACK", ack, 0);
    bus_stop();
    chk(exp_wq.size() == 0 && mem[5] == 8'h3C, "R3 single write of extra-byte transfer", mem[5], 8'h3C);
    chk(mem[6] == ref_mem[6], "R3 neighbour untouched", mem[6], ref_mem[6]);

    // R4: single read
    read_setup(8'h03, ok);
    chk(ok, "R4 read setup ACKs", ok, 1);
    rx_byte(1'b0, b);
    chk(b == 8'hA5, "R4 read data MSB first", b, 8'hA5);
    bus_stop();

    // R5/R6: burst across the wrap point
    read_setup(8'h0E, ok);
    chk(ok, "R5 burst setup ACKs", ok, 1);
    for (int k = 0; k < 4; k++) begin
      logic [7:0] a;
      a = 8'((14 + k) % 16);
      rx_byte(k != 3, b);
      chk(b == ref_mem[a], $sformatf("R6 burst byte %0d", k), b, ref_mem[a]);
    end
    // R5: after NACK the slave keeps SDA released
    rx_byte(1'b0, b);
    chk(b == 8'hFF, "R5 released after master NACK", b, 8'hFF);
    bus_stop();

    // R6: start above the last location
    read_setup(8'h20, ok);
    rx_byte(1'b1, b);
    chk(b == ref_mem[8'h20], "R6 read above 0Fh", b, ref_mem[8'h20]);
    rx_byte(1'b0, b);
    chk(b == ref_mem[0], "R6 wrap from above 0Fh", b, ref_mem[0]);
    bus_stop();

    repeat (10) @(negedge clk);
    chk(stops_seen == stops_exp, "R8 stop pulse count", stops_seen, stops_exp);
    chk(!sda_oe, "R8 SDA released in idle", sda_oe, 0);
    chk(exp_wq.size() == 0, "R9 no pending writes", exp_wq.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule